// File: doc/BRIEF.md
# Power Button Hold Supervisor

This block sits behind an already-debounced power-button level and turns it into host events. Every new press of the button produces a one-cycle press interrupt. When the device is powered down or sleeping at that moment, the press also produces a one-cycle wake request for the power sequencer.

If the button stays down for a programmable number of clock ticks, the block raises a long-press interrupt flag. The host then has a second programmable window in which it can acknowledge the flag with an `ack_pulse` strobe. An acknowledgement clears the flag and cancels the shutdown. If the window runs out without one, the block emits a one-cycle power-down request and clears the flag.

After either outcome, the block ignores the button until the button has been released. Only a fresh press can start a new hold measurement. Both thresholds are parameters in clock ticks, so the real-time values (seconds) come from the clock rate, and simulation can use short values. `LONG_TICKS` must be at least 2 and `ACK_TICKS` at least 1.

Top module: `pwrkey_hold_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `press_irq`, `wake_req`, `long_irq` and `pdown_req` are all low.
- R2: When a clock edge samples `key_level` high after the previous edge sampled it low, `press_irq` is high for exactly the following cycle. This happens in every internal state.
- R3: `wake_req` pulses together with `press_irq` only if `dev_mode` at that sampling edge is 2'b00 (off) or 2'b01 (sleep). The codes 2'b10 and 2'b11 both mean active and give no wake request.
- R4: `long_irq` goes high right after the `LONG_TICKS`-th consecutive edge that sampled `key_level` high, counting the press edge as the first.
- R5: Releasing the button before that edge raises no `long_irq`. The next press starts the hold count from zero.
- R6: Once set, `long_irq` stays high until it is acknowledged or the window expires.
- R7: An `ack_pulse` sampled while `long_irq` is high clears `long_irq` after that edge, and no `pdown_req` follows.
- R8: Without an acknowledgement, `pdown_req` is high for exactly one cycle after the `ACK_TICKS`-th edge following the rise of `long_irq`, and `long_irq` falls in the same cycle. An `ack_pulse` on that last edge wins, and no power-down is requested.
- R9: After an acknowledgement or a power-down request, a button that is still held raises no further `long_irq` until it has been released and pressed again.
- R10: An `ack_pulse` while `long_irq` is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_level | input | 1 | Debounced button level, 1 = pressed |
| ack_pulse | input | 1 | Host acknowledge strobe for the long-press flag |
| dev_mode | input | 2 | Device state: 00 off, 01 sleep, 10/11 active |
| press_irq | output | 1 | One-cycle press interrupt |
| wake_req | output | 1 | One-cycle wake request for presses in off or sleep |
| long_irq | output | 1 | Long-press interrupt flag |
| pdown_req | output | 1 | One-cycle power-down request |

## Verification
Errors in the hold counter appear at the ports as a `long_irq` edge that comes one or more cycles early or late. Because of this, the checks sample the cycle before and the cycle of each expected edge. Errors in the window count show up the same way on `pdown_req`. A sequencer stuck in the wrong state shows up within one press/release cycle, for example:
- a second long-press flag during a continued hold, or
- a missing flag after a short press restarted the count.

A wrong wake decode shows up on the very next press edge.

// File: rtl/pwrkey_pkg.sv
package pwrkey_pkg;

    typedef enum logic [1:0] {
        PWR_OFF        = 2'b00,
        PWR_SLEEP      = 2'b01,
        PWR_ACTIVE     = 2'b10,
        PWR_ACTIVE_ALT = 2'b11
    } pwr_mode_e;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_HOLD,
        KS_ACKWAIT,
        KS_RELWAIT
    } key_state_e;

    typedef struct packed {
        logic press;
        logic wake;
    } edge_evt_t;

    function automatic logic mode_wakes(input logic [1:0] mode);
        return (mode == PWR_OFF) || (mode == PWR_SLEEP);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwrkey_edge.sv
module pwrkey_edge
    import pwrkey_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_level,
    input  logic [1:0] dev_mode,
    output logic       rise_now,
    output edge_evt_t  evt_q
);

    logic key_q;

    assign rise_now = key_level & ~key_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= 1'b0;
            evt_q <= '0;
        end else begin
            key_q      <= key_level;
            evt_q.press <= rise_now;
            evt_q.wake  <= rise_now & mode_wakes(dev_mode);
        end
    end

endmodule

// File: rtl/pwrkey_span_timer.sv
module pwrkey_span_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             at_limit
);

    logic [CNT_W-1:0] cnt;

    assign at_limit = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwrkey_seq.sv
module pwrkey_seq
    import pwrkey_pkg::*;
#(
    parameter int unsigned LONG_TICKS = 6000,
    parameter int unsigned ACK_TICKS  = 2000,
    parameter int unsigned CNT_W      = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic key_level,
    input  logic rise_now,
    input  logic ack_pulse,
    output logic long_flag,
    output logic pdown_pulse
);

    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(LONG_TICKS - 1);
    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(ACK_TICKS - 1);

    key_state_e       state_q, state_d;
    logic             long_d, pdown_d;
    logic             tmr_clr, tmr_en, tmr_hit;
    logic [CNT_W-1:0] tmr_limit;

    pwrkey_span_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr      (tmr_clr),
        .en       (tmr_en),
        .limit    (tmr_limit),
        .at_limit (tmr_hit)
    );

    assign tmr_limit = (state_q == KS_ACKWAIT) ? WIN_LAST : HOLD_LAST;

    always_comb begin
        state_d = state_q;
        long_d  = long_flag;
        pdown_d = 1'b0;
        tmr_clr = 1'b0;
        tmr_en  = 1'b0;
        unique case (state_q)
            KS_IDLE: begin
                if (rise_now) begin
                    state_d = KS_HOLD;
                    tmr_en  = 1'b1;
                end else begin
                    tmr_clr = 1'b1;
                end
            end
            KS_HOLD: begin
                if (!key_level) begin
                    state_d = KS_IDLE;
                    tmr_clr = 1'b1;
                end else if (tmr_hit) begin
                    state_d = KS_ACKWAIT;
                    long_d  = 1'b1;
                    tmr_clr = 1'b1;
                end else begin
                    tmr_en = 1'b1;
                end
            end
            KS_ACKWAIT: begin
                if (ack_pulse) begin
                    state_d = KS_RELWAIT;
                    long_d  = 1'b0;
                    tmr_clr = 1'b1;
                end else if (tmr_hit) begin
                    state_d = KS_RELWAIT;
                    long_d  = 1'b0;
                    pdown_d = 1'b1;
                    tmr_clr = 1'b1;
                end else begin
                    tmr_en = 1'b1;
                end
            end
            KS_RELWAIT: begin
                tmr_clr = 1'b1;
                if (!key_level) begin
                    state_d = KS_IDLE;
                end
            end
            default: begin
                state_d = KS_IDLE;
                tmr_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= KS_IDLE;
            long_flag   <= 1'b0;
            pdown_pulse <= 1'b0;
        end else begin
            state_q     <= state_d;
            long_flag   <= long_d;
            pdown_pulse <= pdown_d;
        end
    end

endmodule

// File: rtl/pwrkey_hold_ctrl.sv
module pwrkey_hold_ctrl
    import pwrkey_pkg::*;
#(
    parameter int unsigned LONG_TICKS = 6000,
    parameter int unsigned ACK_TICKS  = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_level,
    input  logic       ack_pulse,
    input  logic [1:0] dev_mode,
    output logic       press_irq,
    output logic       wake_req,
    output logic       long_irq,
    output logic       pdown_req
);

    localparam int unsigned CNT_W = $clog2(max2(LONG_TICKS, ACK_TICKS) + 1);

    logic      rise_now;
    edge_evt_t evt;

    pwrkey_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .key_level (key_level),
        .dev_mode  (dev_mode),
        .rise_now  (rise_now),
        .evt_q     (evt)
    );

    pwrkey_seq #(
        .LONG_TICKS (LONG_TICKS),
        .ACK_TICKS  (ACK_TICKS),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .key_level   (key_level),
        .rise_now    (rise_now),
        .ack_pulse   (ack_pulse),
        .long_flag   (long_irq),
        .pdown_pulse (pdown_req)
    );

    assign press_irq = evt.press;
    assign wake_req  = evt.wake;

endmodule

// File: rtl/pwrkey_hold_chk.sv
module pwrkey_hold_chk (
    input logic       clk,
    input logic       rst,
    input logic       key_level,
    input logic       ack_pulse,
    input logic [1:0] dev_mode,
    input logic       press_irq,
    input logic       wake_req,
    input logic       long_irq,
    input logic       pdown_req
);

    assert_press_single_R2: assert property (@(posedge clk) disable iff (rst)
        press_irq |=> !press_irq);

    assert_press_cause_R2: assert property (@(posedge clk) disable iff (rst)
        press_irq |-> $past(key_level));

    assert_wake_with_press_R3: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> press_irq);

    assert_wake_mode_R3: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> !$past(dev_mode[1]));

    assert_long_needs_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(long_irq) |-> $past(key_level));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (long_irq && ack_pulse) |=> (!long_irq && !pdown_req));

    assert_pdown_single_R8: assert property (@(posedge clk) disable iff (rst)
        pdown_req |=> !pdown_req);

    assert_pdown_after_flag_R8: assert property (@(posedge clk) disable iff (rst)
        pdown_req |-> ($past(long_irq) && !long_irq));

    assert_no_pdown_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!long_irq && !pdown_req) |=> !pdown_req);

endmodule

bind pwrkey_hold_ctrl pwrkey_hold_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .key_level (key_level),
    .ack_pulse (ack_pulse),
    .dev_mode  (dev_mode),
    .press_irq (press_irq),
    .wake_req  (wake_req),
    .long_irq  (long_irq),
    .pdown_req (pdown_req)
);

// File: tb/pwrkey_hold_ctrl_tb.sv
module pwrkey_hold_ctrl_tb;

    localparam int unsigned L = 10;
    localparam int unsigned A = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_level = 1'b0;
    logic       ack_pulse = 1'b0;
    logic [1:0] dev_mode = 2'b10;
    logic       press_irq, wake_req, long_irq, pdown_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pwrkey_hold_ctrl #(.LONG_TICKS(L), .ACK_TICKS(A)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .key_level (key_level),
        .ack_pulse (ack_pulse),
        .dev_mode  (dev_mode),
        .press_irq (press_irq),
        .wake_req  (wake_req),
        .long_irq  (long_irq),
        .pdown_req (pdown_req)
    );

    // row: key, ack, mode[1:0] | exp press, wake, long, pdown
    localparam logic [7:0] VEC [11] = '{
        8'b0_0_00_0000,
        8'b1_0_00_1100,
        8'b1_0_00_0000,
        8'b0_0_00_0000,
        8'b1_0_10_1000,
        8'b0_0_10_0000,
        8'b1_0_01_1100,
        8'b0_0_01_0000,
        8'b1_0_11_1000,
        8'b0_1_10_0000,
        8'b0_0_10_0000
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic chk_all(input string req, input logic p, input logic w,
                           input logic l, input logic d);
        chk(req, "press_irq", press_irq, p);
        chk(req, "wake_req",  wake_req,  w);
        chk(req, "long_irq",  long_irq,  l);
        chk(req, "pdown_req", pdown_req, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        chk_all("R1", 1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        tick();
        chk_all("R1", 1'b0, 1'b0, 1'b0, 1'b0);

        // R2 R3 R10: vector table of short presses across device modes
        foreach (VEC[i]) begin
            key_level = VEC[i][7];
            ack_pulse = VEC[i][6];
            dev_mode  = VEC[i][5:4];
            tick();
            chk_all("R2/R3/R10 vec", VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end
        ack_pulse = 1'b0;
        dev_mode  = 2'b10;

        // R4 R6 R8 R9: hold, no acknowledge, power-down, continued hold
        key_level = 1'b1;
        tick();
        chk("R2", "press_irq", press_irq, 1'b1);
        for (int i = 2; i < L; i++) tick();
        chk("R4", "long_irq early", long_irq, 1'b0);
        tick();
        chk("R4", "long_irq", long_irq, 1'b1);
        for (int i = 1; i < A; i++) begin
            tick();
            chk("R6", "long_irq held", long_irq, 1'b1);
        end
        chk("R8", "pdown_req early", pdown_req, 1'b0);
        tick();
        chk("R8", "pdown_req", pdown_req, 1'b1);
        chk("R8", "long_irq cleared", long_irq, 1'b0);
        tick();
        chk("R8", "pdown_req single", pdown_req, 1'b0);
        for (int i = 0; i < L + A + 3; i++) begin
            tick();
            chk("R9", "no relong", long_irq | pdown_req, 1'b0);
        end
        key_level = 1'b0;
        tick();
        tick();

        // R5: short hold then restart from zero
        key_level = 1'b1;
        for (int i = 1; i < L; i++) tick();
        key_level = 1'b0;
        tick();
        chk("R5", "long_irq after release", long_irq, 1'b0);
        tick();
        key_level = 1'b1;
        for (int i = 1; i < L; i++) tick();
        chk("R5", "long_irq restart early", long_irq, 1'b0);
        tick();
        chk("R5", "long_irq restart", long_irq, 1'b1);

        // R7: acknowledge cancels power-down
        tick();
        ack_pulse = 1'b1;
        tick();
        ack_pulse = 1'b0;
        chk("R7", "long_irq cleared", long_irq, 1'b0);
        chk("R7", "pdown_req", pdown_req, 1'b0);
        for (int i = 0; i < A + 2; i++) begin
            tick();
            chk("R7", "no pdown", pdown_req | long_irq, 1'b0);
        end
        key_level = 1'b0;
        tick();
        tick();

        // R8: acknowledge on the final window edge wins
        key_level = 1'b1;
        for (int i = 0; i < L; i++) tick();
        chk("R8", "long_irq set", long_irq, 1'b1);
        for (int i = 1; i < A; i++) tick();
        ack_pulse = 1'b1;
        tick();
        ack_pulse = 1'b0;
        chk("R8", "ack priority pdown", pdown_req, 1'b0);
        chk("R8", "ack priority long", long_irq, 1'b0);
        tick();
        chk("R8", "ack priority pdown late", pdown_req, 1'b0);
        key_level = 1'b0;
        tick();

        // R1: reset in the middle of a hold
        key_level = 1'b1;
        for (int i = 0; i < L - 2; i++) tick();
        rst = 1'b1;
        key_level = 1'b0;
        tick();
        chk_all("R1 mid", 1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) tick();
        chk_all("R1 after", 1'b0, 1'b0, 1'b0, 1'b0);

        finish_run();
    end

endmodule